// File: doc/BRIEF.md
# Ethernet receive frame admission filter

This block watches the byte stream of an Ethernet receive path once preamble and start-of-frame delimiter are gone. Each byte arrives with a valid strobe, a start marker on the first destination-address byte and an end marker on the last CRC byte. The filter counts the frame length, compares the six destination-address bytes with the broadcast address and with a station address given on an input port, and decides at the end of the frame whether the frame is kept. It also produces the status flags that a receive descriptor needs and an interrupt pulse for frames that are too long.

A small control register holds the maximum frame length, promiscuous mode, broadcast reject and receive-off-while-transmitting. A transmit-active input lets the filter throw away frames that begin while the local transmitter is sending. The result comes out as a one-cycle strobe with its flags, the cycle after the end byte.

Top module: `rx_admit_filter`

## Requirements
- R1: The control register resets to 0x0000_05EE: max length in bits 10:0 (reset 1518), promiscuous in bit 16, broadcast reject in bit 17, receive-off-while-transmitting in bit 18, all other bits zero. Writes take effect on the next edge and reserved bits always read zero.
- R2: Frame length counts every valid byte from the start-marked byte through the end-marked byte inclusive. The long flag is 1 exactly when that length exceeds the max length field; a frame of exactly max length is not long.
- R3: The interrupt output pulses high for one cycle together with the result strobe of every long frame and is low at all other times.
- R4: The length counter is 12 bits wide for the default 11-bit max-length field and saturates at 4095, so a frame of more than 4096 bytes is still flagged long against a small max length.
- R5: With broadcast reject set and promiscuous clear, a frame whose first six bytes are all 0xFF is dropped (accept=0), with the broadcast flag set.
- R6: With broadcast reject and promiscuous both set, a broadcast frame is accepted with the miss flag set.
- R7: With promiscuous set, every frame is accepted. The miss flag is set when the frame matches neither the station address nor an allowed broadcast; otherwise it is clear.
- R8: With promiscuous clear, a non-broadcast frame is accepted only if its six destination bytes, first byte on the wire equal to station address bits 47:40 and so on down, equal the station address. A broadcast is accepted when broadcast reject is clear. A frame shorter than six bytes matches no address. Miss is 0.
- R9: The result strobe is high for exactly one cycle, the cycle after the clock edge that takes the end-marked byte, and is never high during a frame.
- R10: With receive-off-while-transmitting set, a frame whose start byte arrives while transmit is active produces no result strobe and no interrupt, even if transmit ends before the frame does. A frame already started when transmit rises is received normally.
- R11: With receive-off-while-transmitting clear, transmit activity has no effect on results.
- R12: Valid bytes outside a frame, including an end-marked byte with no preceding start, produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read data |
| sta_addr | input | 48 | Station address, bits 47:40 matched by the first byte |
| tx_active | input | 1 | Local transmitter is sending |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Byte is the first destination-address byte |
| rx_eof | input | 1 | Byte is the last CRC byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Frame is kept |
| res_miss | output | 1 | Accepted only through promiscuous mode |
| res_long | output | 1 | Frame exceeded max length |
| res_bcast | output | 1 | Destination was the broadcast address |
| babble_irq | output | 1 | Oversize-frame interrupt pulse |

## Verification
The bench targets the length boundary at exactly max length and one above, where an off-by-one comparison would flag or miss the wrong frame, and a frame past 4096 bytes against a small limit, where a wrapping counter would report it short. It drives broadcast frames through all four combinations of broadcast reject and promiscuous mode, near-miss addresses differing in one byte, and frames shorter than the address, where a design that reused stale match state would accept them. Transmit is raised at the start of a frame and dropped mid-frame, and raised only after the start, to catch a design that samples transmit continuously instead of at the start byte. Idle gaps inside frames and stray end markers outside frames check that the result strobe neither fires early nor fires twice.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int ADDR_BYTES    = 6;
   localparam logic [7:0] BCAST_BYTE = 8'hFF;
   localparam int CFG_PROM_BIT  = 16;
   localparam int CFG_BCREJ_BIT = 17;
   localparam int CFG_RXOFF_BIT = 18;

   typedef struct packed {
      logic accept;
      logic miss;
      logic long_f;
      logic bcast;
   } rxf_result_t;
endpackage

// File: rtl/rxf_cfg_reg.sv
module rxf_cfg_reg #(
   parameter int LEN_W     = 11,
   parameter int LEN_RESET = 1518
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata,
   output logic [LEN_W-1:0] max_len,
   output logic             promisc,
   output logic             bc_rej,
   output logic             rx_off_tx
);
   import rxf_pkg::*;

   if (LEN_W > CFG_PROM_BIT) begin : g_bad_len_w
      $error("LEN_W overlaps the mode bits");
   end
   if (LEN_RESET >= (1 << LEN_W)) begin : g_bad_reset
      $error("LEN_RESET does not fit in LEN_W bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         max_len   <= LEN_W'(LEN_RESET);
         promisc   <= 1'b0;
         bc_rej    <= 1'b0;
         rx_off_tx <= 1'b0;
      end else if (wr) begin
         max_len   <= wdata[LEN_W-1:0];
         promisc   <= wdata[CFG_PROM_BIT];
         bc_rej    <= wdata[CFG_BCREJ_BIT];
         rx_off_tx <= wdata[CFG_RXOFF_BIT];
      end
   end

   always_comb begin
      rdata                = '0;
      rdata[LEN_W-1:0]     = max_len;
      rdata[CFG_PROM_BIT]  = promisc;
      rdata[CFG_BCREJ_BIT] = bc_rej;
      rdata[CFG_RXOFF_BIT] = rx_off_tx;
   end
endmodule

// File: rtl/rxf_len_cnt.sv
module rxf_len_cnt #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   output logic [CNT_W-1:0] cnt_prev,
   output logic [CNT_W-1:0] cnt_now
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;

   assign cnt_prev = restart ? '0 : cnt_q;
   assign cnt_now  = (cnt_prev == CNT_MAX) ? CNT_MAX : cnt_prev + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_now;
   end
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   input  logic [CNT_W-1:0] byte_idx,
   input  logic [7:0]       data,
   input  logic [47:0]      sta_addr,
   output logic             bc_now,
   output logic             sa_now
);
   import rxf_pkg::*;

   logic [7:0] sta_b [ADDR_BYTES];
   logic       bc_q, sa_q, bc_prev, sa_prev, in_da;
   logic [7:0] sta_sel;

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta_byte
      assign sta_b[g] = sta_addr[47-8*g -: 8];
   end

   assign in_da   = (byte_idx < CNT_W'(ADDR_BYTES));
   assign sta_sel = in_da ? sta_b[byte_idx[2:0]] : 8'h00;
   assign bc_prev = restart ? 1'b1 : bc_q;
   assign sa_prev = restart ? 1'b1 : sa_q;
   assign bc_now  = bc_prev & (!in_da | (data == BCAST_BYTE));
   assign sa_now  = sa_prev & (!in_da | (data == sta_sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bc_q <= 1'b0;
         sa_q <= 1'b0;
      end else if (step) begin
         bc_q <= bc_now;
         sa_q <= sa_now;
      end
   end
endmodule

// File: rtl/rx_admit_filter.sv
module rx_admit_filter #(
   parameter int LEN_W     = 11,
   parameter int LEN_RESET = 1518
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic [47:0] sta_addr,
   input  logic        tx_active,
   input  logic        rx_valid,
   input  logic [7:0]  rx_data,
   input  logic        rx_sof,
   input  logic        rx_eof,
   output logic        res_valid,
   output logic        res_accept,
   output logic        res_miss,
   output logic        res_long,
   output logic        res_bcast,
   output logic        babble_irq
);
   import rxf_pkg::*;

   localparam int CNT_W = LEN_W + 1;

   logic [LEN_W-1:0] max_len;
   logic             promisc, bc_rej, rx_off_tx;
   logic             in_frame_q, drop_q, drop_now, step, done, full_da;
   logic             bc_now, sa_now, bcast, match;
   logic [CNT_W-1:0] cnt_prev, cnt_now;
   rxf_result_t      res_d, res_q;

   rxf_cfg_reg #(.LEN_W(LEN_W), .LEN_RESET(LEN_RESET)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .max_len(max_len), .promisc(promisc),
      .bc_rej(bc_rej), .rx_off_tx(rx_off_tx)
   );

   assign step     = rx_valid & (rx_sof | in_frame_q);
   assign drop_now = rx_sof ? (rx_off_tx & tx_active) : drop_q;
   assign done     = step & rx_eof & !drop_now;

   rxf_len_cnt #(.CNT_W(CNT_W)) u_len (
      .clk(clk), .rst_n(rst_n), .step(step), .restart(rx_sof),
      .cnt_prev(cnt_prev), .cnt_now(cnt_now)
   );

   rxf_addr_match #(.CNT_W(CNT_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .step(step), .restart(rx_sof),
      .byte_idx(cnt_prev), .data(rx_data), .sta_addr(sta_addr),
      .bc_now(bc_now), .sa_now(sa_now)
   );

   assign full_da = (cnt_now >= CNT_W'(ADDR_BYTES));
   assign bcast   = full_da & bc_now;
   assign match   = full_da & sa_now;

   always_comb begin
      res_d.bcast  = bcast;
      res_d.long_f = (cnt_now > {1'b0, max_len});
      if (promisc) begin
         res_d.accept = 1'b1;
         res_d.miss   = bcast ? bc_rej : !match;
      end else begin
         res_d.accept = bcast ? !bc_rej : match;
         res_d.miss   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         drop_q     <= 1'b0;
         res_valid  <= 1'b0;
         res_q      <= '0;
      end else begin
         if (step) begin
            in_frame_q <= !rx_eof;
            drop_q     <= drop_now;
         end
         res_valid <= done;
         if (done) res_q <= res_d;
      end
   end

   assign res_accept = res_valid & res_q.accept;
   assign res_miss   = res_valid & res_q.miss;
   assign res_long   = res_valid & res_q.long_f;
   assign res_bcast  = res_valid & res_q.bcast;
   assign babble_irq = res_valid & res_q.long_f;
endmodule

// File: rtl/rx_admit_filter_chk.sv
module rx_admit_filter_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_valid,
   input logic        rx_eof,
   input logic [31:0] cfg_rdata,
   input logic        res_valid,
   input logic        res_accept,
   input logic        res_miss,
   input logic        res_long,
   input logic        res_bcast,
   input logic        babble_irq
);
   import rxf_pkg::*;

   AST_RESULT_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(rx_valid && rx_eof)); // R9
   AST_IRQ_ONLY_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      babble_irq |-> (res_valid && res_long)); // R3
   AST_LONG_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_long) |-> babble_irq); // R3
   AST_PROM_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && $past(cfg_rdata[CFG_PROM_BIT])) |-> res_accept); // R7
   AST_MISS_NEEDS_PROM: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_miss) |-> $past(cfg_rdata[CFG_PROM_BIT])); // R8
   AST_BCAST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_bcast && $past(cfg_rdata[CFG_BCREJ_BIT])
       && !$past(cfg_rdata[CFG_PROM_BIT])) |-> !res_accept); // R5
   AST_BCAST_PROM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_bcast && $past(cfg_rdata[CFG_BCREJ_BIT])
       && $past(cfg_rdata[CFG_PROM_BIT])) |-> (res_accept && res_miss)); // R6
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[31:19] == 13'd0) && (cfg_rdata[15:11] == 5'd0)); // R1
endmodule

bind rx_admit_filter rx_admit_filter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof),
   .cfg_rdata(cfg_rdata), .res_valid(res_valid), .res_accept(res_accept),
   .res_miss(res_miss), .res_long(res_long), .res_bcast(res_bcast),
   .babble_irq(babble_irq)
);

// File: tb/rx_admit_filter_test.sv
module rx_admit_filter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [47:0] sta_addr = 48'h02_1A_3C_55_9E_07;
   logic        tx_active = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_sof = 1'b0;
   logic        rx_eof = 1'b0;
   logic        res_valid, res_accept, res_miss, res_long, res_bcast, babble_irq;

   int vectors = 0;
   int errors  = 0;
   logic [7:0] fbuf [0:4199];
   logic [10:0] m_max = 11'd1518;
   logic m_prom = 0, m_bcrej = 0, m_rxoff = 0;
   bit   early;

   rx_admit_filter uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .sta_addr(sta_addr), .tx_active(tx_active),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .res_valid(res_valid), .res_accept(res_accept), .res_miss(res_miss),
      .res_long(res_long), .res_bcast(res_bcast), .babble_irq(babble_irq)
   );

   always #10 clk = ~clk;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic wr_cfg(logic [10:0] ml, logic p, logic b, logic d);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = {13'd0, d, b, p, 5'd0, ml};
      @(negedge clk);
      cfg_wr = 1'b0;
      m_max = ml; m_prom = p; m_bcrej = b; m_rxoff = d;
   endtask

   // kind 0 station, 1 broadcast, 2 random, 3 near miss
   task automatic fill(int n, int kind);
      for (int i = 0; i < n; i++) fbuf[i] = 8'($urandom);
      for (int i = 0; i < 6 && i < n; i++) begin
         case (kind)
            0: fbuf[i] = sta_addr[47-8*i -: 8];
            1: fbuf[i] = 8'hFF;
            3: fbuf[i] = sta_addr[47-8*i -: 8];
            default: ;
         endcase
      end
      if (kind == 3 && n > 0) begin
         int k = int'($urandom_range(0, (n < 6 ? n : 6) - 1));
         fbuf[k] = fbuf[k] ^ 8'h10;
      end
      if (kind == 2 && n > 0 && fbuf[0] == sta_addr[47:40]) fbuf[0] = ~fbuf[0];
   endtask

   // txmode 0 none, 1 high at start then low after 3 bytes, 2 rises after start
   task automatic send(int n, int txmode, bit gaps);
      early = 0;
      for (int i = 0; i < n; i++) begin
         if (gaps && ($urandom_range(0, 7) == 0)) begin
            @(negedge clk);
            if (res_valid) early = 1;
            rx_valid = 1'b0;
         end
         @(negedge clk);
         if (res_valid) early = 1;
         rx_valid = 1'b1;
         rx_data  = fbuf[i];
         rx_sof   = (i == 0);
         rx_eof   = (i == n - 1);
         tx_active = (txmode == 1) ? (i < 3) : (txmode == 2) ? (i >= 1) : 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; tx_active = 1'b0;
   endtask

   task automatic run_frame(int n, int kind, int txmode, bit gaps);
      bit full, bc, sa, drop, ev, ea, em, el;
      string tag, ltag;
      int len;
      fill(n, kind);
      len  = (n > 4095) ? 4095 : n;
      full = (n >= 6);
      bc = full; sa = full;
      for (int i = 0; i < 6 && i < n; i++) begin
         if (fbuf[i] != 8'hFF) bc = 0;
         if (fbuf[i] != sta_addr[47-8*i -: 8]) sa = 0;
      end
      drop = m_rxoff && (txmode == 1);
      ev = !drop;
      if (m_prom) begin ea = 1; em = bc ? m_bcrej : !sa; end
      else begin ea = bc ? !m_bcrej : sa; em = 0; end
      el = (len > int'(m_max));
      if (drop) tag = "R10";
      else if (txmode != 0 && !m_rxoff) tag = "R11";
      else if (txmode != 0) tag = "R10";
      else if (m_prom && bc && m_bcrej) tag = "R6";
      else if (m_prom) tag = "R7";
      else if (bc && m_bcrej) tag = "R5";
      else tag = "R8";
      ltag = (n > 4095) ? "R4" : "R2";
      send(n, txmode, gaps);
      chk("R9", "no strobe during frame", 32'(early), 32'd0);
      chk((ev ? "R9" : tag), "result strobe", 32'(res_valid), 32'(ev));
      if (ev) begin
         chk(tag, "accept", 32'(res_accept), 32'(ea));
         chk(tag, "miss", 32'(res_miss), 32'(em));
         chk("R8", "bcast flag", 32'(res_bcast), 32'(bc));
         chk(ltag, "long flag", 32'(res_long), 32'(el));
      end
      chk("R3", "irq", 32'(babble_irq), 32'(ev && el));
      @(negedge clk);
      chk("R9", "strobe one cycle", 32'(res_valid), 32'd0);
      chk("R3", "irq one cycle", 32'(babble_irq), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      chk("R1", "reset config", cfg_rdata, 32'h0000_05EE);
      chk("R9", "reset strobe", 32'(res_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R1", "reserved bits read zero", cfg_rdata, 32'h0007_07FF);
      wr_cfg(11'd1518, 0, 0, 0);
      chk("R1", "readback", cfg_rdata, 32'h0000_05EE);

      // length boundary
      run_frame(1518, 0, 0, 0);
      run_frame(1519, 0, 0, 0);
      wr_cfg(11'd64, 0, 0, 0);
      run_frame(64, 0, 0, 0);
      run_frame(65, 2, 0, 0);
      // saturation
      wr_cfg(11'd10, 0, 0, 0);
      run_frame(4102, 0, 0, 0);
      wr_cfg(11'd1518, 0, 0, 0);
      // broadcast under all mode pairs
      for (int m = 0; m < 4; m++) begin
         wr_cfg(11'd1518, m[0], m[1], 0);
         run_frame(20, 1, 0, 0);
         run_frame(20, 2, 0, 0);
         run_frame(20, 0, 0, 0);
         run_frame(4, 0, 0, 0);
      end
      // transmit interaction
      wr_cfg(11'd1518, 0, 0, 1);
      run_frame(30, 0, 1, 0);
      run_frame(30, 0, 0, 0);
      run_frame(30, 0, 2, 0);
      run_frame(1, 0, 1, 0);
      wr_cfg(11'd1518, 0, 0, 0);
      run_frame(30, 0, 1, 0);
      // stray bytes outside any frame
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'hFF; rx_eof = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; rx_eof = 1'b0;
      chk("R12", "stray end byte", 32'(res_valid), 32'd0);
      @(negedge clk);
      chk("R12", "stray end byte later", 32'(res_valid), 32'd0);
      run_frame(12, 0, 0, 0);

      // random mix
      for (int t = 0; t < 300; t++) begin
         if (t % 25 == 0)
            wr_cfg(11'($urandom_range(20, 80)), 1'($urandom), 1'($urandom), 1'($urandom));
         run_frame(int'($urandom_range(1, 90)), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 2)), 1'b1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule